// File: doc/BRIEF.md
# Banked Register File Operand Collector

This block sits between instruction issue and the dispatch units of a many-warp core. It fetches the source operands of each issued instruction from a register file that is split into single-ported banks. An accepted instruction takes a free collector slot. The slot then raises read requests to the banks that hold its source registers. One arbiter per bank picks a single reader per cycle. A crossbar steers each bank's read data back to the slot that won it. When a slot holds every operand it needs, it offers the instruction, its warp and its operand values on one dispatch port.

A register of a given warp sits in bank (warp + register) mod the bank count. Because of this, the same register number in different warps lands in different banks. Reads that fall into distinct banks all finish in the same cycle. Reads that meet in one bank wait their turn. The register file has one write port per bank, fed by a single writeback input. A write takes its bank ahead of any read in that cycle.

Top module: `bankedOperandCollector`

## Requirements
- R1: Register r of warp w is stored in bank (w + r) mod NB, at row (w*REGS + r) >> log2(NB). A value written through the writeback input is the value later returned for that warp and register. Source slot s of `dispData` occupies bits [s*DW +: DW].
- R2: A bank serves at most one read per cycle. An instruction that is accepted alone, into an idle block, and whose used sources sit in distinct banks raises `dispValid` on the first clock edge after the edge that accepted it.
- R3: Different registers of one instruction that map to the same bank are read one per cycle. With three such sources, `dispValid` rises on the third edge after acceptance.
- R4: Each bank arbiter rotates among collectors. After collector c wins a bank, any other collector that requests that bank in the next cycle wins ahead of c.
- R5: `issueReady` is high exactly when a collector is free, and an instruction is taken on an edge where `issueValid` and `issueReady` are both high. With all NC collectors occupied, `issueReady` is low and further instructions are not taken.
- R6: A writeback to a bank blocks reads of that bank in the same cycle. The blocked read retries on the next cycle and returns the newly written value.
- R7: `issueSrcUse[s]` marks source slot s as used. Unused slots need no read and deliver zero. A register that appears in two used slots is read once, and both slots fill in the same cycle.
- R8: Once `dispValid` is high it stays high, with the same tag, warp and data, until `dispReady` is high. The collector frees on that edge. When the port is idle, the lowest-numbered complete collector is offered.
- R9: After reset no collector is occupied: `issueReady` is 1 and `dispValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issued instruction present |
| issueReady | output | 1 | A collector is free |
| issueWarp | input | WW | Warp of the issued instruction |
| issueTag | input | TW | Caller's instruction tag |
| issueSrcUse | input | NS | One bit per source slot in use |
| issueSrcReg | input | NS*RW | Source register numbers, slot s at [s*RW +: RW] |
| wbValid | input | 1 | Writeback request |
| wbWarp | input | WW | Writeback warp |
| wbReg | input | RW | Writeback register |
| wbData | input | DW | Writeback value |
| dispValid | output | 1 | A complete instruction is offered |
| dispReady | input | 1 | Dispatch unit accepts |
| dispWarp | output | WW | Warp of the offered instruction |
| dispTag | output | TW | Tag of the offered instruction |
| dispData | output | NS*DW | Operand values, slot s at [s*DW +: DW] |

## Verification
The bench builds the block with its defaults: 16 banks, 4 collectors, 3 source slots, 8 warps, 48 registers per warp, 32-bit data and 8-bit tags. With 48 registers, one warp has three registers in a single bank (for example 0, 16 and 32 of warp 0), so a lone instruction can show the serialized reads. Warp 1 register 15 shares that bank, which lets two collectors compete and exposes the rotating grant. With only four collectors, a short burst fills them all and shows the issue back-pressure. The random traffic keeps writebacks in warp 7 and reads in warps 0 to 6. Write-to-read conflicts on shared banks then happen often, while the expected operand values stay unambiguous.

// File: rtl/ocPkg.sv
package ocPkg;

  // Per-bank strobes handed from the control to the datapath.
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } bankStrobeT;

endpackage

// File: rtl/ocBankArb.sv
module ocBankArb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  input  logic          block,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gntIdx
);

  logic [IW-1:0] ptr;

  // Search begins at the pointer and wraps around; the nearest requester wins.
  always_comb begin
    int k;
    gnt    = '0;
    gntIdx = '0;
    k      = 0;
    if (!block) begin
      for (int i = N - 1; i >= 0; i--) begin
        k = (int'(ptr) + i) % N;
        if (req[k]) begin
          gnt    = '0;
          gnt[k] = 1'b1;
          gntIdx = IW'(k);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (|gnt) begin
      ptr <= (gntIdx == IW'(N - 1)) ? '0 : gntIdx + 1'b1;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt) && ((gnt & ~req) == '0));  // R2

  AST_WB_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rstN)
    block |-> (gnt == '0));  // R6

  AST_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (|gnt) |=> ((!block && ((req & ~$past(gnt)) != '0)) -> ((gnt & $past(gnt)) == '0)));  // R4

endmodule

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
#(
  parameter int NB   = 16,
  parameter int NC   = 4,
  parameter int NS   = 3,
  parameter int NW   = 8,
  parameter int REGS = 48,
  parameter int TW   = 8,
  localparam int BW   = $clog2(NB),
  localparam int CW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int WW   = (NW > 1) ? $clog2(NW) : 1,
  localparam int RW   = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int SLW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int DEPTH = NW * REGS / NB,
  localparam int ROWW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(NW * REGS) + 1,
  localparam int SW   = ((RW > WW) ? RW : WW) + 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              issueValid,
  output logic                              issueReady,
  input  logic [WW-1:0]                     issueWarp,
  input  logic [TW-1:0]                     issueTag,
  input  logic [NS-1:0]                     issueSrcUse,
  input  logic [NS*RW-1:0]                  issueSrcReg,
  input  logic                              wbValid,
  input  logic [WW-1:0]                     wbWarp,
  input  logic [RW-1:0]                     wbReg,
  output logic                              dispValid,
  input  logic                              dispReady,
  output logic [WW-1:0]                     dispWarp,
  output logic [TW-1:0]                     dispTag,
  output bankStrobeT [NB-1:0]               bankStb,
  output logic [NB-1:0][ROWW-1:0]           rdRow,
  output logic [ROWW-1:0]                   wrRow,
  output logic [NC-1:0][NS-1:0]             capEn,
  output logic [NC-1:0][NS-1:0][BW-1:0]     capBank,
  output logic [NC-1:0]                     clrEn,
  output logic [CW-1:0]                     dispSel
);

  function automatic logic [BW-1:0] bankOf(input logic [WW-1:0] w, input logic [RW-1:0] r);
    logic [SW-1:0] sum;
    sum = SW'(w) + SW'(r);
    return sum[BW-1:0];
  endfunction

  function automatic logic [ROWW-1:0] rowOf(input logic [WW-1:0] w, input logic [RW-1:0] r);
    logic [FW-1:0] flat;
    flat = FW'(w) * FW'(REGS) + FW'(r);
    return ROWW'(flat >> BW);
  endfunction

  // Collector state
  logic [NC-1:0]                 cValid;
  logic [NC-1:0][WW-1:0]         cWarp;
  logic [NC-1:0][TW-1:0]         cTag;
  logic [NC-1:0][NS-1:0][RW-1:0] cReg;
  logic [NC-1:0][NS-1:0]         cPend;

  logic                          holdSel;
  logic [CW-1:0]                 holdIdx;

  logic [NC-1:0][NS-1:0][BW-1:0] opBank;
  logic [NB-1:0][NC-1:0]         reqVec;
  logic [NB-1:0][NC-1:0][SLW-1:0] reqSlot;
  logic [NB-1:0][NC-1:0]         gnt;
  logic [NB-1:0][CW-1:0]         gntIdx;
  logic [NB-1:0]                 wrHit;
  logic [BW-1:0]                 wrBank;
  logic [NC-1:0]                 full;
  logic [CW-1:0]                 lowFull;
  logic [CW-1:0]                 allocIdx;
  logic                          alloc;
  logic                          dispFire;

  // Operand bank lookup and per-bank request vectors
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        opBank[c][s] = bankOf(cWarp[c], cReg[c][s]);
      end
    end
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < NC; c++) begin
        reqVec[b][c]  = 1'b0;
        reqSlot[b][c] = '0;
        for (int s = NS - 1; s >= 0; s--) begin
          if (cValid[c] && cPend[c][s] && opBank[c][s] == BW'(b)) begin
            reqVec[b][c]  = 1'b1;
            reqSlot[b][c] = SLW'(s);
          end
        end
      end
    end
  end

  // Writeback claims its bank first
  assign wrBank = bankOf(wbWarp, wbReg);
  assign wrRow  = rowOf(wbWarp, wbReg);

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_bank
      assign wrHit[gb] = wbValid && (wrBank == BW'(gb));

      ocBankArb #(.N(NC)) arb_i (
        .clk    (clk),
        .rstN   (rstN),
        .req    (reqVec[gb]),
        .block  (wrHit[gb]),
        .gnt    (gnt[gb]),
        .gntIdx (gntIdx[gb])
      );

      assign bankStb[gb].rdEn = |gnt[gb];
      assign bankStb[gb].wrEn = wrHit[gb];
      assign rdRow[gb] = rowOf(cWarp[gntIdx[gb]], cReg[gntIdx[gb]][reqSlot[gb][gntIdx[gb]]]);
    end
  endgenerate

  // Crossbar capture: every pending slot naming the granted register fills at once
  always_comb begin
    logic [BW-1:0] bk;
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        bk            = opBank[c][s];
        capBank[c][s] = bk;
        capEn[c][s]   = cValid[c] && cPend[c][s] && gnt[bk][c] &&
                        (cReg[c][s] == cReg[c][reqSlot[bk][c]]);
      end
    end
  end

  // Allocation and dispatch selection
  always_comb begin
    allocIdx = '0;
    lowFull  = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      full[c] = cValid[c] && (cPend[c] == '0);
      if (!cValid[c]) allocIdx = CW'(c);
      if (full[c])    lowFull  = CW'(c);
    end
  end

  assign issueReady = ~&cValid;
  assign alloc      = issueValid && issueReady;
  assign dispValid  = holdSel || (|full);
  assign dispSel    = holdSel ? holdIdx : lowFull;
  assign dispFire   = dispValid && dispReady;
  assign dispWarp   = cWarp[dispSel];
  assign dispTag    = cTag[dispSel];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      clrEn[c] = alloc && (allocIdx == CW'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cValid  <= '0;
      cWarp   <= '0;
      cTag    <= '0;
      cReg    <= '0;
      cPend   <= '0;
      holdSel <= 1'b0;
      holdIdx <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (clrEn[c]) begin
          cValid[c] <= 1'b1;
          cWarp[c]  <= issueWarp;
          cTag[c]   <= issueTag;
          cPend[c]  <= issueSrcUse;
          for (int s = 0; s < NS; s++) begin
            cReg[c][s] <= issueSrcReg[s*RW +: RW];
          end
        end else begin
          if (dispFire && dispSel == CW'(c)) cValid[c] <= 1'b0;
          cPend[c] <= cPend[c] & ~capEn[c];
        end
      end
      if (dispFire) begin
        holdSel <= 1'b0;
      end else if (dispValid) begin
        holdSel <= 1'b1;
        holdIdx <= dispSel;
      end
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NC; gc++) begin : g_chk
      AST_PEND_NEVER_SETS: assert property (@(posedge clk) disable iff (!rstN)
        ($past(cValid[gc]) && cValid[gc]) |-> ((cPend[gc] & ~$past(cPend[gc])) == '0));  // R7
    end
  endgenerate

  AST_DISP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady) |=> (dispValid && dispTag == $past(dispTag) && dispWarp == $past(dispWarp)));  // R8

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (&cValid)) |=> ($countones(cValid) == $countones($past(cValid)) || $past(dispFire)));  // R5

endmodule

// File: rtl/ocData.sv
module ocData
  import ocPkg::*;
#(
  parameter int NB    = 16,
  parameter int NC    = 4,
  parameter int NS    = 3,
  parameter int DW    = 32,
  parameter int DEPTH = 24,
  localparam int BW   = $clog2(NB),
  localparam int CW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int ROWW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobeT [NB-1:0]           bankStb,
  input  logic [NB-1:0][ROWW-1:0]       rdRow,
  input  logic [ROWW-1:0]               wrRow,
  input  logic [DW-1:0]                 wbData,
  input  logic [NC-1:0][NS-1:0]         capEn,
  input  logic [NC-1:0][NS-1:0][BW-1:0] capBank,
  input  logic [NC-1:0]                 clrEn,
  input  logic [CW-1:0]                 dispSel,
  output logic [NS*DW-1:0]              dispData
);

  logic [NB-1:0][DW-1:0]         rdData;
  logic [NC-1:0][NS-1:0][DW-1:0] opData;

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_bank
      logic [DW-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
        if (bankStb[gb].wrEn) store[wrRow] <= wbData;
      end

      assign rdData[gb] = store[rdRow[gb]];

      AST_ONE_PORT_USE: assert property (@(posedge clk) disable iff (!rstN)
        !(bankStb[gb].rdEn && bankStb[gb].wrEn));  // R6
    end
  endgenerate

  // Crossbar from bank read ports into collector operand registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opData <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        for (int s = 0; s < NS; s++) begin
          if (clrEn[c])         opData[c][s] <= '0;
          else if (capEn[c][s]) opData[c][s] <= rdData[capBank[c][s]];
        end
      end
    end
  end

  assign dispData = opData[dispSel];

endmodule

// File: rtl/bankedOperandCollector.sv
module bankedOperandCollector
  import ocPkg::*;
#(
  parameter int NB   = 16,
  parameter int NC   = 4,
  parameter int NS   = 3,
  parameter int NW   = 8,
  parameter int REGS = 48,
  parameter int DW   = 32,
  parameter int TW   = 8,
  localparam int BW    = $clog2(NB),
  localparam int CW    = (NC > 1) ? $clog2(NC) : 1,
  localparam int WW    = (NW > 1) ? $clog2(NW) : 1,
  localparam int RW    = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int DEPTH = NW * REGS / NB,
  localparam int ROWW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  output logic             issueReady,
  input  logic [WW-1:0]    issueWarp,
  input  logic [TW-1:0]    issueTag,
  input  logic [NS-1:0]    issueSrcUse,
  input  logic [NS*RW-1:0] issueSrcReg,
  input  logic             wbValid,
  input  logic [WW-1:0]    wbWarp,
  input  logic [RW-1:0]    wbReg,
  input  logic [DW-1:0]    wbData,
  output logic             dispValid,
  input  logic             dispReady,
  output logic [WW-1:0]    dispWarp,
  output logic [TW-1:0]    dispTag,
  output logic [NS*DW-1:0] dispData
);

  bankStrobeT [NB-1:0]           bankStb;
  logic [NB-1:0][ROWW-1:0]       rdRow;
  logic [ROWW-1:0]               wrRow;
  logic [NC-1:0][NS-1:0]         capEn;
  logic [NC-1:0][NS-1:0][BW-1:0] capBank;
  logic [NC-1:0]                 clrEn;
  logic [CW-1:0]                 dispSel;

  ocCtrl #(
    .NB(NB), .NC(NC), .NS(NS), .NW(NW), .REGS(REGS), .TW(TW)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .issueReady  (issueReady),
    .issueWarp   (issueWarp),
    .issueTag    (issueTag),
    .issueSrcUse (issueSrcUse),
    .issueSrcReg (issueSrcReg),
    .wbValid     (wbValid),
    .wbWarp      (wbWarp),
    .wbReg       (wbReg),
    .dispValid   (dispValid),
    .dispReady   (dispReady),
    .dispWarp    (dispWarp),
    .dispTag     (dispTag),
    .bankStb     (bankStb),
    .rdRow       (rdRow),
    .wrRow       (wrRow),
    .capEn       (capEn),
    .capBank     (capBank),
    .clrEn       (clrEn),
    .dispSel     (dispSel)
  );

  ocData #(
    .NB(NB), .NC(NC), .NS(NS), .DW(DW), .DEPTH(DEPTH)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .bankStb  (bankStb),
    .rdRow    (rdRow),
    .wrRow    (wrRow),
    .wbData   (wbData),
    .capEn    (capEn),
    .capBank  (capBank),
    .clrEn    (clrEn),
    .dispSel  (dispSel),
    .dispData (dispData)
  );

endmodule

// File: tb/bankedOperandCollector_tb_top.sv
module bankedOperandCollector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic          issueReady;
  logic [2:0]    issueWarp = '0;
  logic [7:0]    issueTag = '0;
  logic [2:0]    issueSrcUse = '0;
  logic [17:0]   issueSrcReg = '0;
  logic          wbValid = 1'b0;
  logic [2:0]    wbWarp = '0;
  logic [5:0]    wbReg = '0;
  logic [31:0]   wbData = '0;
  logic          dispValid;
  logic          dispReady = 1'b0;
  logic [2:0]    dispWarp;
  logic [7:0]    dispTag;
  logic [95:0]   dispData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bankedOperandCollector dut_i (
    .clk, .rstN, .issueValid, .issueReady, .issueWarp, .issueTag, .issueSrcUse,
    .issueSrcReg, .wbValid, .wbWarp, .wbReg, .wbData, .dispValid, .dispReady,
    .dispWarp, .dispTag, .dispData
  );

  logic [31:0] rfModel [8][48];
  logic [2:0]  sbWarp [256];
  logic [95:0] sbData [256];
  bit          sbBusy [256];
  int          checks = 0;
  int          fails = 0;
  int          inFlight = 0;
  logic [7:0]  nextTag = '0;

  function automatic logic [31:0] initVal(input int w, input int r);
    return 32'h9E37_79B9 * (w * 48 + r + 1) ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One clock: account for what the coming edge does, then move to the next falling edge.
  task automatic tick();
    if (dispValid && dispReady) begin
      chk(sbBusy[dispTag], "R8 dispatched tag is outstanding", 128'(sbBusy[dispTag]), 128'd1);
      chk(dispWarp == sbWarp[dispTag], "R1 dispatched warp", 128'(dispWarp), 128'(sbWarp[dispTag]));
      chk(dispData == sbData[dispTag], "R1 operand data", 128'(dispData), 128'(sbData[dispTag]));
      sbBusy[dispTag] = 1'b0;
      inFlight--;
    end
    if (wbValid) rfModel[wbWarp][wbReg] = wbData;
    if (issueValid && issueReady) begin
      logic [95:0] e;
      for (int s = 0; s < NS; s++) begin
        e[s*DW +: DW] = issueSrcUse[s] ? rfModel[issueWarp][issueSrcReg[s*6 +: 6]] : 32'd0;
      end
      sbData[issueTag] = e;
      sbWarp[issueTag] = issueWarp;
      sbBusy[issueTag] = 1'b1;
      inFlight++;
      nextTag = nextTag + 8'd1;
    end
    @(negedge clk);
  endtask

  task automatic setIssue(input int w, input int r0, input int r1, input int r2, input logic [2:0] use3);
    issueValid  = 1'b1;
    issueWarp   = 3'(w);
    issueTag    = nextTag;
    issueSrcUse = use3;
    issueSrcReg = {6'(r2), 6'(r1), 6'(r0)};
  endtask

  task automatic drain();
    issueValid = 1'b0;
    wbValid    = 1'b0;
    dispReady  = 1'b1;
    for (int i = 0; i < 60 && inFlight > 0; i++) tick();
    chk(inFlight == 0, "R5 all instructions dispatched", 128'(inFlight), 128'd0);
    dispReady = 1'b0;
  endtask

  initial begin
    logic [7:0] tagA;
    logic [7:0] tagB;
    logic [7:0] first;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) sbBusy[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(issueReady == 1'b1, "R9 issueReady after reset", 128'(issueReady), 128'd1);
    chk(dispValid == 1'b0, "R9 dispValid after reset", 128'(dispValid), 128'd0);

    // Preload every register through the writeback port
    for (int w = 0; w < 8; w++) begin
      for (int r = 0; r < 48; r++) begin
        wbValid = 1'b1; wbWarp = 3'(w); wbReg = 6'(r); wbData = initVal(w, r);
        tick();
      end
    end
    wbValid = 1'b0;

    // R4: A holds three bank-0 reads, B one; B wins the second grant
    tagA = nextTag;
    setIssue(0, 0, 16, 32, 3'b111);
    tick();
    tagB = nextTag;
    setIssue(1, 15, 0, 0, 3'b001);
    tick();
    issueValid = 1'b0;
    chk(dispValid == 1'b0, "R4 nothing complete after first grant", 128'(dispValid), 128'd0);
    tick();
    chk(dispValid == 1'b1 && dispTag == tagB, "R4 rotating grant serves second collector",
        128'({dispValid, dispTag}), 128'({1'b1, tagB}));
    chk(tagA != tagB, "R4 distinct tags", 128'(tagA), 128'(tagB));
    drain();

    // R2: three sources in distinct banks finish in one cycle
    setIssue(3, 0, 1, 2, 3'b111);
    tick();
    issueValid = 1'b0;
    chk(dispValid == 1'b0, "R2 not ready on accept edge", 128'(dispValid), 128'd0);
    tick();
    chk(dispValid == 1'b1, "R2 ready one edge after accept", 128'(dispValid), 128'd1);
    drain();

    // R3: three registers in one bank serialize
    setIssue(0, 0, 16, 32, 3'b111);
    tick();
    issueValid = 1'b0;
    tick();
    tick();
    chk(dispValid == 1'b0, "R3 not ready after two edges", 128'(dispValid), 128'd0);
    tick();
    chk(dispValid == 1'b1, "R3 ready after three edges", 128'(dispValid), 128'd1);
    drain();

    // R7: duplicate register read once, unused slot zero
    setIssue(4, 5, 5, 9, 3'b011);
    tick();
    issueValid = 1'b0;
    tick();
    chk(dispValid == 1'b1, "R7 duplicate register fills both slots at once", 128'(dispValid), 128'd1);
    chk(dispData[95:64] == 32'd0, "R7 unused slot is zero", 128'(dispData[95:64]), 128'd0);
    drain();

    // R6: writeback to a source bank delays the read and supplies the new value
    tagA = nextTag;
    setIssue(2, 1, 2, 3, 3'b111);
    tick();
    issueValid = 1'b0;
    wbValid = 1'b1; wbWarp = 3'd2; wbReg = 6'd1; wbData = 32'hC0FF_EE01;
    chk(dispValid == 1'b0, "R6 not ready on accept edge", 128'(dispValid), 128'd0);
    tick();
    wbValid = 1'b0;
    sbData[tagA][31:0] = 32'hC0FF_EE01;
    chk(dispValid == 1'b0, "R6 read blocked by writeback", 128'(dispValid), 128'd0);
    tick();
    chk(dispValid == 1'b1, "R6 read retried next cycle", 128'(dispValid), 128'd1);
    chk(dispData[31:0] == 32'hC0FF_EE01, "R6 new value returned", 128'(dispData[31:0]), 128'hC0FFEE01);
    drain();

    // R5 and R8: fill all collectors, then back-pressure and held offer
    first = nextTag;
    for (int i = 0; i < 4; i++) begin
      setIssue(5, i, 0, 0, 3'b001);
      tick();
    end
    chk(issueReady == 1'b0, "R5 no free collector", 128'(issueReady), 128'd0);
    setIssue(5, 7, 0, 0, 3'b001);
    tick();
    chk(issueReady == 1'b0, "R5 fifth instruction not taken", 128'(issueReady), 128'd0);
    chk(dispValid && dispTag == first, "R8 lowest collector offered", 128'(dispTag), 128'(first));
    issueValid = 1'b0;
    tick();
    chk(dispValid && dispTag == first, "R8 offer held while not ready", 128'(dispTag), 128'(first));
    dispReady = 1'b1;
    tick();
    dispReady = 1'b0;
    chk(issueReady == 1'b1, "R5 collector freed by dispatch", 128'(issueReady), 128'd1);
    drain();

    // Random traffic: reads in warps 0..6, writebacks into warp 7
    for (int n = 0; n < 4000; n++) begin
      issueValid  = ($urandom % 3) != 0;
      issueWarp   = 3'($urandom % 7);
      issueTag    = nextTag;
      issueSrcUse = 3'($urandom % 8);
      issueSrcReg = {6'($urandom % 48), 6'($urandom % 48), 6'($urandom % 48)};
      wbValid     = ($urandom % 3) == 0;
      wbWarp      = 3'd7;
      wbReg       = 6'($urandom % 48);
      wbData      = $urandom;
      dispReady   = ($urandom % 4) != 0;
      tick();
    end
    drain();

    // Read back warp 7 to confirm the random writebacks (R1)
    dispReady = 1'b1;
    for (int i = 0; i < 16; i++) begin
      setIssue(7, 3 * i, 3 * i + 1, 3 * i + 2, 3'b111);
      for (int t = 0; t < 20; t++) begin
        automatic bit acc = issueReady;
        tick();
        if (acc) break;
      end
      issueValid = 1'b0;
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule